// File: doc/BRIEF.md
# Multi-Client Poll Transfer Sequencer

This block times one host-side poll exchange with a group of wireless clients. A single start pulse begins a fixed series of phases: a preamble, the host data frame, a window in which the polled clients answer, and a short acknowledge frame. All phase lengths are counted in ticks of an external strobe, normally one tick per microsecond. The block raises an interrupt pulse as each frame begins transmission and as each frame ends. At the close of the exchange it raises a final interrupt, a one-cycle done pulse and a success flag.

The reply window is sized from the number of clients addressed in a 16-bit mask. Each client is granted a base slot plus a programmable reply time, and a fixed overhead is added on top. Each phase drives its own radio status and pin code, so the analog front end can follow the exchange. The retry decision is made outside the block. The block only samples the two verdict inputs when the acknowledge frame ends.

Top module: `pts_sequencer`

## Requirements
- R1: While reset is held and on the first cycle after it, the status is 0, the pin code is 0x0000, busy and done are low and no interrupt pulse is raised.
- R2: A start seen while idle makes busy rise on the next cycle and enters the preamble, which lasts PRE_TICKS ticks. Status is 3 and pins are 0x0046 during the preamble. The start interrupt pulses for one cycle when the preamble ends.
- R3: The data phase lasts the sampled data length in ticks, with a length of 0 treated as 1. Status is 3 and pins are 0x0046 during it. When it ends, the transmit-end interrupt pulses for one cycle, and only if its enable input is high.
- R4: The reply window lasts 112 + (10 + reply_time) × N ticks, where N is the number of set bits in the client mask sampled at start. Status is 5 and pins are 0x0084 during the window.
- R5: When the reply window ends, the start interrupt pulses again. The acknowledge frame then lasts ACK_TICKS ticks (128 by default, for 16 bytes at 1 Mbps), with status 8 and pins 0x0046.
- R6: When the acknowledge ends, done pulses for exactly one cycle. The success output takes the replies-ok input sampled at that edge and holds it until the next done. The transmit-end interrupt pulses there as well if it is enabled.
- R7: The final interrupt pulses together with done if and only if replies-ok or no-retry is high at the end of the acknowledge.
- R8: After the first completed exchange, the idle status is 9 and the pin code is 0x0000.
- R9: A start received while busy is ignored. The mask, reply time and data length are sampled only on an accepted start, so later changes to them have no effect on the running exchange.
- R10: Phases advance only on cycles where the tick strobe is high. Every interrupt and done pulse lasts one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an exchange (accepted only when idle) |
| client_mask_i | input | 16 | Clients polled in this exchange |
| reply_time_i | input | 8 | Extra reply ticks granted per client |
| data_ticks_i | input | 12 | Length of the host data frame in ticks |
| tick_i | input | 1 | Time-base strobe, one per microsecond |
| txend_irq_en_i | input | 1 | Enables the transmit-end interrupt |
| replies_ok_i | input | 1 | All clients answered (sampled at acknowledge end) |
| no_retry_i | input | 1 | No time left for a retry (sampled at acknowledge end) |
| irq_start_o | output | 1 | Pulse: a frame begins transmission |
| irq_txend_o | output | 1 | Pulse: a frame has finished |
| irq_final_o | output | 1 | Pulse: exchange over, with success or no retry left |
| rf_status_o | output | 4 | Radio status code of the current phase |
| rf_pins_o | output | 16 | Radio pin code of the current phase |
| busy_o | output | 1 | An exchange is in progress |
| done_o | output | 1 | Pulse: exchange finished |
| success_o | output | 1 | Verdict of the last finished exchange |

## Verification
The bench shortens PRE_TICKS to 8 and keeps the default 16-client mask, 8-bit reply time and 128-tick acknowledge. It can therefore drive the widest reply window (all sixteen clients at the largest reply time, 4352 ticks) alongside the narrowest one (empty mask, 112 ticks) and the zero-length data clamp. The tick strobe is held low on random cycles, so every phase boundary is checked against counted ticks rather than clock cycles.

// File: rtl/pts_pkg.sv
package pts_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_DATA,
        PH_WAIT,
        PH_ACK
    } phase_e;

    typedef struct packed {
        logic start;
        logic txend;
        logic fin;
        logic done;
    } events_s;

    localparam logic [3:0]  ST_RESET = 4'd0;
    localparam logic [3:0]  ST_TX    = 4'd3;
    localparam logic [3:0]  ST_WAIT  = 4'd5;
    localparam logic [3:0]  ST_ACK   = 4'd8;
    localparam logic [3:0]  ST_IDLE  = 4'd9;

    localparam logic [15:0] PINS_IDLE = 16'h0000;
    localparam logic [15:0] PINS_TX   = 16'h0046;
    localparam logic [15:0] PINS_WAIT = 16'h0084;

    localparam int WINDOW_BASE = 112;
    localparam int SLOT_BASE   = 10;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pts_window_calc.sv
module pts_window_calc
    import pts_pkg::*;
#(
    parameter int CLIENTS = 16,
    parameter int RT_W    = 8,
    parameter int CNT_W   = 16
) (
    input  logic [CLIENTS-1:0] mask_i,
    input  logic [RT_W-1:0]    reply_time_i,
    output logic [CNT_W-1:0]   window_o
);

    logic [CNT_W-1:0] partial [0:CLIENTS];

    assign partial[0] = '0;

    for (genvar i = 0; i < CLIENTS; i++) begin : g_pop
        assign partial[i+1] = partial[i] + CNT_W'(mask_i[i]);
    end

    logic [CNT_W-1:0] per_client;
    assign per_client = CNT_W'(SLOT_BASE) + CNT_W'(reply_time_i);
    assign window_o   = CNT_W'(WINDOW_BASE) + per_client * partial[CLIENTS];

endmodule

// File: rtl/pts_phase_timer.sv
module pts_phase_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_q;

    assign expire_o = tick_i && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (tick_i && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/pts_status_map.sv
module pts_status_map
    import pts_pkg::*;
(
    input  phase_e      phase_i,
    input  logic        used_i,
    output logic [3:0]  status_o,
    output logic [15:0] pins_o
);

    always_comb begin
        status_o = ST_RESET;
        pins_o   = PINS_IDLE;
        case (phase_i)
            PH_IDLE: begin
                status_o = used_i ? ST_IDLE : ST_RESET;
                pins_o   = PINS_IDLE;
            end
            PH_PRE, PH_DATA: begin
                status_o = ST_TX;
                pins_o   = PINS_TX;
            end
            PH_WAIT: begin
                status_o = ST_WAIT;
                pins_o   = PINS_WAIT;
            end
            PH_ACK: begin
                status_o = ST_ACK;
                pins_o   = PINS_TX;
            end
            default: begin
                status_o = ST_RESET;
                pins_o   = PINS_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/pts_sequencer.sv
module pts_sequencer
    import pts_pkg::*;
#(
    parameter int CLIENTS   = 16,
    parameter int RT_W      = 8,
    parameter int LEN_W     = 12,
    parameter int PRE_TICKS = 96,
    parameter int ACK_TICKS = 128
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [CLIENTS-1:0] client_mask_i,
    input  logic [RT_W-1:0]    reply_time_i,
    input  logic [LEN_W-1:0]   data_ticks_i,
    input  logic               tick_i,
    input  logic               txend_irq_en_i,
    input  logic               replies_ok_i,
    input  logic               no_retry_i,
    output logic               irq_start_o,
    output logic               irq_txend_o,
    output logic               irq_final_o,
    output logic [3:0]         rf_status_o,
    output logic [15:0]        rf_pins_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               success_o
);

    localparam int WIN_MAX = WINDOW_BASE + (SLOT_BASE + (2**RT_W) - 1) * CLIENTS;
    localparam int LEN_MAX = (2**LEN_W) - 1;
    localparam int ALL_MAX = imax(imax(WIN_MAX, LEN_MAX), imax(PRE_TICKS, ACK_TICKS));
    localparam int CNT_W   = $clog2(ALL_MAX + 1);

    phase_e           phase_q, phase_n;
    events_s          ev_n, ev_q;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expire;
    logic [CNT_W-1:0] win_calc, win_q, dlen_q;
    logic             used_q, success_q;
    logic             accept;

    assign accept = (phase_q == PH_IDLE) && start_i;

    pts_window_calc #(
        .CLIENTS (CLIENTS),
        .RT_W    (RT_W),
        .CNT_W   (CNT_W)
    ) u_window (
        .mask_i       (client_mask_i),
        .reply_time_i (reply_time_i),
        .window_o     (win_calc)
    );

    pts_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load),
        .load_val_i (load_val),
        .tick_i     (tick_i),
        .expire_o   (expire)
    );

    pts_status_map u_map (
        .phase_i  (phase_q),
        .used_i   (used_q),
        .status_o (rf_status_o),
        .pins_o   (rf_pins_o)
    );

    always_comb begin
        phase_n  = phase_q;
        load     = 1'b0;
        load_val = '0;
        ev_n     = '0;
        case (phase_q)
            PH_IDLE: begin
                if (start_i) begin
                    phase_n  = PH_PRE;
                    load     = 1'b1;
                    load_val = CNT_W'(PRE_TICKS);
                end
            end
            PH_PRE: begin
                if (expire) begin
                    phase_n    = PH_DATA;
                    load       = 1'b1;
                    load_val   = dlen_q;
                    ev_n.start = 1'b1;
                end
            end
            PH_DATA: begin
                if (expire) begin
                    phase_n    = PH_WAIT;
                    load       = 1'b1;
                    load_val   = win_q;
                    ev_n.txend = txend_irq_en_i;
                end
            end
            PH_WAIT: begin
                if (expire) begin
                    phase_n    = PH_ACK;
                    load       = 1'b1;
                    load_val   = CNT_W'(ACK_TICKS);
                    ev_n.start = 1'b1;
                end
            end
            PH_ACK: begin
                if (expire) begin
                    phase_n    = PH_IDLE;
                    ev_n.txend = txend_irq_en_i;
                    ev_n.fin   = replies_ok_i || no_retry_i;
                    ev_n.done  = 1'b1;
                end
            end
            default: phase_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            ev_q      <= '0;
            win_q     <= '0;
            dlen_q    <= '0;
            used_q    <= 1'b0;
            success_q <= 1'b0;
        end else begin
            phase_q <= phase_n;
            ev_q    <= ev_n;
            if (accept) begin
                win_q  <= win_calc;
                dlen_q <= (data_ticks_i == '0) ? CNT_W'(1) : CNT_W'(data_ticks_i);
            end
            if (ev_n.done) begin
                success_q <= replies_ok_i;
                used_q    <= 1'b1;
            end
        end
    end

    assign irq_start_o = ev_q.start;
    assign irq_txend_o = ev_q.txend;
    assign irq_final_o = ev_q.fin;
    assign done_o      = ev_q.done;
    assign busy_o      = (phase_q != PH_IDLE);
    assign success_o   = success_q;

endmodule

// File: rtl/pts_sequencer_chk.sv
module pts_sequencer_chk (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic        replies_ok_i,
    input logic        no_retry_i,
    input logic        irq_start_o,
    input logic        irq_final_o,
    input logic [3:0]  rf_status_o,
    input logic        busy_o,
    input logic        done_o,
    input logic        success_o
);

    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> busy_o); // R2

    AST_START_IRQ_PHASE: assert property (@(posedge clk) disable iff (rst)
        irq_start_o |-> (rf_status_o == 4'd3 || rf_status_o == 4'd8)); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R10

    AST_DONE_FROM_ACK: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(rf_status_o) == 4'd8 && !busy_o)); // R6

    AST_SUCCESS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(success_o)); // R6

    AST_FINAL_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        irq_final_o |-> (done_o && $past(replies_ok_i || no_retry_i))); // R7

    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (rf_status_o == 4'd9)); // R8

endmodule

bind pts_sequencer pts_sequencer_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .replies_ok_i (replies_ok_i),
    .no_retry_i   (no_retry_i),
    .irq_start_o  (irq_start_o),
    .irq_final_o  (irq_final_o),
    .rf_status_o  (rf_status_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .success_o    (success_o)
);

// File: tb/pts_sequencer_tb.sv
module pts_sequencer_tb;

    localparam int PRE = 8;
    localparam int ACK = 128;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [15:0] client_mask_i;
    logic [7:0]  reply_time_i;
    logic [11:0] data_ticks_i;
    logic        tick_i;
    logic        txend_irq_en_i;
    logic        replies_ok_i;
    logic        no_retry_i;
    logic        irq_start_o, irq_txend_o, irq_final_o;
    logic [3:0]  rf_status_o;
    logic [15:0] rf_pins_o;
    logic        busy_o, done_o, success_o;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pts_sequencer #(
        .PRE_TICKS (PRE),
        .ACK_TICKS (ACK)
    ) u_dut (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start_i),
        .client_mask_i  (client_mask_i),
        .reply_time_i   (reply_time_i),
        .data_ticks_i   (data_ticks_i),
        .tick_i         (tick_i),
        .txend_irq_en_i (txend_irq_en_i),
        .replies_ok_i   (replies_ok_i),
        .no_retry_i     (no_retry_i),
        .irq_start_o    (irq_start_o),
        .irq_txend_o    (irq_txend_o),
        .irq_final_o    (irq_final_o),
        .rf_status_o    (rf_status_o),
        .rf_pins_o      (rf_pins_o),
        .busy_o         (busy_o),
        .done_o         (done_o),
        .success_o      (success_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int win_len(input logic [15:0] m, input int rt);
        int n = 0;
        for (int i = 0; i < 16; i++) if (m[i]) n++;
        return 112 + (10 + rt) * n;
    endfunction

    // expected {status, pins} after c ticks
    function automatic int exp_code(input int c, input int p, input int d,
                                    input int w, input int t);
        if (c < p + d)  return (3 << 16) | 16'h0046;
        if (c < p + d + w) return (5 << 16) | 16'h0084;
        if (c < t)      return (8 << 16) | 16'h0046;
        return (9 << 16) | 16'h0000;
    endfunction

    task automatic xfer(input logic [15:0] mask, input int rt, input int dl,
                        input bit en, input bit ok, input bit nr, input bit poke);
        int  d = (dl == 0) ? 1 : dl;
        int  w = win_len(mask, rt);
        int  t = PRE + d + w + ACK;
        int  c = 0;
        bit  lt = 1'b0;
        bit  poked = 1'b0;
        int  ec;
        string rq;
        @(negedge clk);
        client_mask_i  = mask;
        reply_time_i   = 8'(rt);
        data_ticks_i   = 12'(dl);
        txend_irq_en_i = en;
        replies_ok_i   = ok;
        no_retry_i     = nr;
        start_i        = 1'b1;
        tick_i         = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        while (1) begin
            ec = exp_code(c, PRE, d, w, t);
            if (c < PRE + d) rq = "R2,R3";
            else if (c < PRE + d + w) rq = "R4";
            else if (c < t) rq = "R5";
            else rq = "R8";
            chk({rf_status_o, rf_pins_o} == 20'(ec), rq, "status/pins",
                {rf_status_o, rf_pins_o}, ec);
            chk(busy_o == (c < t), "R2", "busy", busy_o, (c < t));
            chk(irq_start_o == (lt && (c == PRE || c == PRE + d + w)),
                "R2,R5,R10", "irq_start", irq_start_o,
                (lt && (c == PRE || c == PRE + d + w)));
            chk(irq_txend_o == (en && lt && (c == PRE + d || c == t)),
                "R3,R6", "irq_txend", irq_txend_o,
                (en && lt && (c == PRE + d || c == t)));
            chk(done_o == (lt && c == t), "R6", "done", done_o, (lt && c == t));
            chk(irq_final_o == (lt && c == t && (ok || nr)), "R7", "irq_final",
                irq_final_o, (lt && c == t && (ok || nr)));
            if (c == t) begin
                chk(success_o == ok, "R6", "success", success_o, ok);
                break;
            end
            if (poke && !poked && c == PRE + 2) begin
                // R9: start and new settings while busy must be ignored
                start_i       = 1'b1;
                client_mask_i = ~mask;
                reply_time_i  = 8'(rt + 37);
                data_ticks_i  = 12'(dl + 50);
                poked         = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            lt = ($urandom % 4) != 0;   // R10: tick gaps
            tick_i = lt;
            @(negedge clk);
            if (lt) c++;
        end
        start_i = 1'b0;
        tick_i  = 1'b0;
        @(negedge clk);
        chk(done_o == 1'b0, "R10", "done one cycle", done_o, 0);
        chk(rf_status_o == 4'd9 && !busy_o, "R8", "idle status", rf_status_o, 9);
        chk(success_o == ok, "R6", "success held", success_o, ok);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1'b1;
        start_i = 1'b0;
        client_mask_i = '0;
        reply_time_i = '0;
        data_ticks_i = '0;
        tick_i = 1'b0;
        txend_irq_en_i = 1'b0;
        replies_ok_i = 1'b0;
        no_retry_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(rf_status_o == 4'd0 && rf_pins_o == 16'h0 && !busy_o && !done_o,
            "R1", "reset outputs", {rf_status_o, rf_pins_o}, 0);
        chk(!irq_start_o && !irq_txend_o && !irq_final_o, "R1", "reset irqs",
            {irq_start_o, irq_txend_o, irq_final_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(rf_status_o == 4'd0 && !busy_o, "R1", "after reset", rf_status_o, 0);

        // empty mask, zero data length (clamped to 1)
        xfer(16'h0000, 0, 0, 1'b1, 1'b1, 1'b0, 1'b0);
        // widest window
        xfer(16'hFFFF, 255, 5, 1'b1, 1'b0, 1'b1, 1'b0);
        // start while busy, irq enable off, no verdict
        xfer(16'h0001, 0, 3, 1'b0, 1'b0, 1'b0, 1'b1);
        // random exchanges
        for (int k = 0; k < 10; k++) begin
            xfer(16'($urandom), int'($urandom % 64), int'($urandom % 40),
                 1'($urandom), 1'($urandom), 1'($urandom), (k % 3) == 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule